// File: doc/BRIEF.md
# Mode-Controlled GPIO Port

This block is a small general-purpose I/O port with a parameterised number of pins (eight by default). Software reaches it over a simple synchronous register bus that exposes two registers. The mode register holds one 2-bit field per pin. The data register holds one bit per pin. The mode field of a pin decides four things: whether the pin is handed to an on-chip peripheral, whether the stored data bit drives the pad, whether the pad pull-up is switched on, and what a read of the data register returns for that pin.

In the two input modes, a read returns the pad level after a two-flop synchroniser. In the other two modes, a read returns the stored bit, so software sees its last write even when that write never reached the pad. A write to the data register always updates the stored bit, whatever the mode. The stored bit reaches the pad only while the pin is in output mode. Read data is registered and appears on the cycle after the read strobe.

Top module: `gpio_mode_port`

## Requirements
- R1: Mode code 00 (alternate function) makes pin n's output value and output enable equal to the alternate-function inputs alt_out[n] and alt_oe[n], with the pull-up off.
- R2: Mode code 01 (output) asserts pin_oe[n] and drives pin_out[n] with the stored data bit n, with the pull-up off.
- R3: Mode codes 10 and 11 (inputs) deassert pin_oe[n] and hold pin_out[n] at 0; pin_pu[n] is asserted in mode 10 only, and in no other mode.
- R4: A bus write with bus_addr=0 stores bus_wdata[NUM_PINS-1:0] in the data register in every mode; the stored value reaches the pads once the pin enters mode 01.
- R5: A read of the data register (bus_addr=0) returns the stored bit for each pin in mode 00 or 01.
- R6: A read of the data register returns the pad level for each pin in mode 10 or 11, taken after a two-flop synchroniser; a level applied at the same edge as the read strobe is not yet visible.
- R7: The mode register (bus_addr=1) is 2*NUM_PINS bits wide, pin n at bits [2n+1:2n], and every bit reads back as written.
- R8: Read data is registered, valid from the clock edge that samples bus_rd, and held unchanged while bus_rd is low; data register reads return 0 in bits above NUM_PINS-1.
- R9: Synchronous reset clears the data register to 0 and sets every mode field to 11, so all pins are inputs with pull-up off and no output enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 1 | Register select: 0 data, 1 mode |
| bus_wdata | input | 2*NUM_PINS | Write data |
| bus_rdata | output | 2*NUM_PINS | Registered read data |
| pin_in | input | NUM_PINS | Pad input levels (asynchronous) |
| alt_out | input | NUM_PINS | Alternate-function output values |
| alt_oe | input | NUM_PINS | Alternate-function output enables |
| pin_out | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables |
| pin_pu | output | NUM_PINS | Pad pull-up enables |

## Verification
The bench builds the port with its defaults: eight pins, a 16-bit bus and a two-stage synchroniser. With these values, every one of the four mode codes can sit on two pins at once in a single mode-register pattern. That lets one access check read-back selection, pad drive and pull-up control side by side for all modes. With eight pins, the zero-filled upper byte of a data read is also visible on the 16-bit bus. A two-stage synchroniser gives a short gap between a pad change and its first appearance in read data, so the bench can probe that gap directly with a single cycle of offset.

// File: rtl/gpio_mode_pkg.sv
package gpio_mode_pkg;

    localparam int MODE_BITS = 2;

    typedef enum logic [MODE_BITS-1:0] {
        PM_ALT      = 2'b00,
        PM_DRIVE    = 2'b01,
        PM_IN_PULL  = 2'b10,
        PM_IN_FLOAT = 2'b11
    } pin_mode_e;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_MODE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic out;
        logic oe;
        logic pu;
    } pad_ctl_t;

    function automatic pad_ctl_t pad_for_mode(
        input pin_mode_e m,
        input logic      stored,
        input logic      a_out,
        input logic      a_oe
    );
        pad_ctl_t p;
        case (m)
            PM_ALT:     p = '{out: a_out,  oe: a_oe, pu: 1'b0};
            PM_DRIVE:   p = '{out: stored, oe: 1'b1, pu: 1'b0};
            PM_IN_PULL: p = '{out: 1'b0,   oe: 1'b0, pu: 1'b1};
            default:    p = '{out: 1'b0,   oe: 1'b0, pu: 1'b0};
        endcase
        return p;
    endfunction

    function automatic logic mode_reads_pad(input pin_mode_e m);
        return (m == PM_IN_PULL) || (m == PM_IN_FLOAT);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_mode_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  reg_sel_e                      sel,
    input  logic [MODE_BITS*NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0]           data_q,
    output logic [MODE_BITS*NUM_PINS-1:0] mode_q
);
    localparam int MODE_W = MODE_BITS * NUM_PINS;

    logic data_we;
    logic mode_we;

    assign data_we = wr_en && (sel == REG_DATA);
    assign mode_we = wr_en && (sel == REG_MODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (data_we) begin
            data_q <= wdata[NUM_PINS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= {NUM_PINS{PM_IN_FLOAT}};
        end else if (mode_we) begin
            mode_q <= wdata[MODE_W-1:0];
        end
    end

    AST_RESET_VALUES: assert property (@(posedge clk)
        rst |=> (data_q == '0) && (mode_q == {MODE_W{1'b1}})); // R9
    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_DATA) |=> data_q == $past(wdata[NUM_PINS-1:0])); // R4
    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_MODE) |=> mode_q == $past(wdata)); // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == REG_DATA) |=> $stable(data_q)); // R4

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_mode_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic [MODE_BITS*NUM_PINS-1:0] mode_q,
    input  logic [NUM_PINS-1:0]           data_q,
    input  logic [NUM_PINS-1:0]           alt_out,
    input  logic [NUM_PINS-1:0]           alt_oe,
    output logic [NUM_PINS-1:0]           pin_out,
    output logic [NUM_PINS-1:0]           pin_oe,
    output logic [NUM_PINS-1:0]           pin_pu
);
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        pin_mode_e mode_n;
        pad_ctl_t  pad_n;

        assign mode_n     = pin_mode_e'(mode_q[MODE_BITS*n +: MODE_BITS]);
        assign pad_n      = pad_for_mode(mode_n, data_q[n], alt_out[n], alt_oe[n]);
        assign pin_out[n] = pad_n.out;
        assign pin_oe[n]  = pad_n.oe;
        assign pin_pu[n]  = pad_n.pu;
    end

endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
    import gpio_mode_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_en,
    input  reg_sel_e                      sel,
    input  logic [MODE_BITS*NUM_PINS-1:0] mode_q,
    input  logic [NUM_PINS-1:0]           data_q,
    input  logic [NUM_PINS-1:0]           pad_sync,
    output logic [MODE_BITS*NUM_PINS-1:0] rdata_q
);
    localparam int BUS_W = MODE_BITS * NUM_PINS;

    logic [NUM_PINS-1:0] data_bits;
    logic [BUS_W-1:0]    data_view;
    logic [BUS_W-1:0]    rd_next;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_bit
        pin_mode_e mode_n;
        assign mode_n       = pin_mode_e'(mode_q[MODE_BITS*n +: MODE_BITS]);
        assign data_bits[n] = mode_reads_pad(mode_n) ? pad_sync[n] : data_q[n];
    end

    always_comb begin
        data_view                 = '0;
        data_view[NUM_PINS-1:0]   = data_bits;
        rd_next = (sel == REG_MODE) ? mode_q : data_view;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_next;
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata_q)); // R8
    AST_RD_MODE_VALUE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == REG_MODE) |=> rdata_q == $past(mode_q)); // R7
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == REG_DATA) |=> rdata_q[BUS_W-1:NUM_PINS] == '0); // R8

endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
    import gpio_mode_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BUS_W       = MODE_BITS * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic                bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] alt_out,
    input  logic [NUM_PINS-1:0] alt_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_pu
);
    localparam int MODE_W = MODE_BITS * NUM_PINS;

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] data_q;
    logic [MODE_W-1:0]   mode_q;
    logic [NUM_PINS-1:0] pad_sync;

    assign sel = reg_sel_e'(bus_addr);

    gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .sel    (sel),
        .wdata  (bus_wdata[MODE_W-1:0]),
        .data_q (data_q),
        .mode_q (mode_q)
    );

    gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pad_sync)
    );

    gpio_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .mode_q  (mode_q),
        .data_q  (data_q),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_pu  (pin_pu)
    );

    gpio_readback #(.NUM_PINS(NUM_PINS)) u_rb (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (bus_rd),
        .sel      (sel),
        .mode_q   (mode_q),
        .data_q   (data_q),
        .pad_sync (pad_sync),
        .rdata_q  (bus_rdata)
    );

    AST_PU_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & pin_oe) == '0); // R3

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
        AST_DRIVE_PIN: assert property (@(posedge clk) disable iff (rst)
            (mode_q[MODE_BITS*n +: MODE_BITS] == 2'b01) |-> (pin_oe[n] && pin_out[n] == data_q[n] && !pin_pu[n])); // R2
        AST_ALT_PIN: assert property (@(posedge clk) disable iff (rst)
            (mode_q[MODE_BITS*n +: MODE_BITS] == 2'b00) |-> (pin_oe[n] == alt_oe[n] && pin_out[n] == alt_out[n] && !pin_pu[n])); // R1
        AST_INPUT_PIN: assert property (@(posedge clk) disable iff (rst)
            mode_q[MODE_BITS*n+1] |-> (!pin_oe[n] && !pin_out[n])); // R3
    end

endmodule

// File: tb/test_gpio_mode_port.sv
module test_gpio_mode_port;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int BW = 16;

    typedef struct packed {
        logic [15:0] mode;
        logic [7:0]  data;
        logic [7:0]  pads;
        logic [7:0]  a_out;
        logic [7:0]  a_oe;
        logic [7:0]  e_out;
        logic [7:0]  e_oe;
        logic [7:0]  e_pu;
        logic [7:0]  e_rd;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16'h5555, 8'hA5, 8'h3C, 8'hFF, 8'hFF, 8'hA5, 8'hFF, 8'h00, 8'hA5},
        '{16'h0000, 8'h5A, 8'h0F, 8'h96, 8'h33, 8'h96, 8'h33, 8'h00, 8'h5A},
        '{16'hAAAA, 8'hFF, 8'h81, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h81},
        '{16'hFFFF, 8'h00, 8'hC3, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hC3},
        '{16'hE4E4, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h33, 8'h33, 8'h44, 8'h33},
        '{16'hE4E4, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h22, 8'h44, 8'hCC}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic          bus_addr = 1'b0;
    logic [BW-1:0] bus_wdata = '0;
    logic [BW-1:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] alt_out = '0;
    logic [NP-1:0] alt_oe = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] pin_pu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mode_port i_gpio_mode_port (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .alt_out   (alt_out),
        .alt_oe    (alt_oe),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_pu    (pin_pu)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic addr, input logic [15:0] val);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = val;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic addr, output logic [15:0] val);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = addr;
        @(negedge clk);
        bus_rd = 1'b0;
        val = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R9: reset state
        check("R9 pin_oe after reset", {8'h00, pin_oe}, 16'h0000);
        check("R9 pin_pu after reset", {8'h00, pin_pu}, 16'h0000);
        check("R9 pin_out after reset", {8'h00, pin_out}, 16'h0000);
        rd(1'b1, r); check("R9 mode reset value", r, 16'hFFFF);
        rd(1'b0, r); check("R9 data reads pad 0 in mode 11", r, 16'h0000);

        // Table walk: R1 R2 R3 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            wr(1'b1, VECS[v].mode);
            wr(1'b0, {8'h00, VECS[v].data});
            pin_in = VECS[v].pads; alt_out = VECS[v].a_out; alt_oe = VECS[v].a_oe;
            idle(3);
            check($sformatf("R1/R2/R3 pin_out vec%0d", v), {8'h00, pin_out}, {8'h00, VECS[v].e_out});
            check($sformatf("R1/R2/R3 pin_oe vec%0d", v),  {8'h00, pin_oe},  {8'h00, VECS[v].e_oe});
            check($sformatf("R3 pin_pu vec%0d", v),        {8'h00, pin_pu},  {8'h00, VECS[v].e_pu});
            rd(1'b0, r);
            check($sformatf("R5/R6 data read vec%0d", v), r, {8'h00, VECS[v].e_rd});
            rd(1'b1, r);
            check($sformatf("R7 mode read vec%0d", v), r, VECS[v].mode);
        end

        // R4: write in input mode does not reach pad, then appears in output mode
        wr(1'b1, 16'hFFFF);
        wr(1'b0, 16'h003C);
        idle(1);
        check("R4 write in mode 11 no pad effect", {8'h00, pin_out}, 16'h0000);
        wr(1'b1, 16'h5555);
        check("R4 stored value driven in mode 01", {8'h00, pin_out}, 16'h003C);
        rd(1'b0, r); check("R4 stored bits read back", r, 16'h003C);

        // R6: synchroniser latency in mode 11
        wr(1'b1, 16'hFFFF);
        pin_in = 8'h00;
        idle(4);
        @(negedge clk);
        pin_in = 8'hFF; bus_rd = 1'b1; bus_addr = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R6 new pad level not yet visible", bus_rdata, 16'h0000);
        idle(3);
        rd(1'b0, r); check("R6 pad level visible, upper byte zero R8", r, 16'h00FF);

        // R8: read data held while no strobe
        pin_in = 8'h0F;
        idle(5);
        check("R8 rdata held without strobe", bus_rdata, 16'h00FF);

        // R7: odd pattern per field
        wr(1'b1, 16'h1B6C);
        rd(1'b1, r); check("R7 mode pattern readback", r, 16'h1B6C);

        // R9: reset mid-operation
        wr(1'b0, 16'h00AA);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R9 pin_oe after second reset", {8'h00, pin_oe}, 16'h0000);
        pin_in = 8'h00;
        idle(3);
        rd(1'b1, r); check("R9 mode after second reset", r, 16'hFFFF);
        wr(1'b1, 16'h5555);
        check("R9 data cleared by reset", {8'h00, pin_out}, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule